// File: doc/BRIEF.md
# Battery-Backed Byte Memory Port Controller

This block is a clock-synchronous model of a byte-wide asynchronous memory port with a backup supply. Three active-low strobes are sampled on every rising clock edge: chip select, output enable and write strobe. From them the block decides whether the port is deselected, reading or writing. Reads return the addressed byte on a data output that has its own drive-enable, so the chip-level pad can be tri-stated. A write begins once both chip select and write strobe are active. The byte is stored when either strobe goes inactive, and a minimum idle gap is then enforced before the next access.

Two supply-status flags come from outside comparators: one says the main supply is above the power-fail level, the other says it is above the battery-switch level. Each passes through a two-flop synchronizer and a debounce filter. While the main supply is below the power-fail level, the port is locked: nothing is read, nothing is written and a write already in flight is dropped. A parameter picks which threshold moves the supply select to the backup source. The stored bytes survive every lockout and battery period.

Top module: `nvram_port_ctrl`

## Requirements
- R1: While chip select is high (inactive), the drive-enable is low one edge later and no byte is stored, whatever output enable and write strobe do.
- R2: With chip select low, write strobe high and output enable low at an edge, drive-enable is high after that edge and the data output carries the byte at the sampled address. With output enable high, drive-enable stays low.
- R3: With chip select and write strobe both low, the port is in write mode whatever output enable does. Once drive-enable is low in write mode, it stays low for as long as write mode lasts.
- R4: If the port is driving read data and write strobe then falls (output enable still low), drive-enable stays high for WEZ_CYC more edges with the read data of the current address. It drops at the next edge after that.
- R5: A write starts at the first edge where both chip select and write strobe are low, whichever fell last. The address is captured at that edge. The byte stored is the data input sampled at the last edge where both were low. The store takes place at the first edge where either one is high.
- R6: For REC_CYC edges after the edge that stores a byte, an access with chip select low is rejected. Such an access raises rec_violation for exactly one cycle, never drives the bus and never writes. It stays rejected until chip select returns high, even when the gap expires while chip select is still low.
- R7: While lockout is high, drive-enable is low one edge later and no byte is written. lockout is high while the filtered main-supply flag is low.
- R8: With LOW_V = 0, on_battery follows the filtered battery-switch flag, inverted. It does not depend on the main-supply flag.
- R9: With LOW_V = 1, on_battery follows the filtered main-supply flag, inverted. The battery-switch flag is ignored.
- R10: If lockout rises while a write is in progress, the write is dropped and the addressed byte keeps its old value.
- R11: Each supply flag changes its filtered value only after the synchronized raw value has differed from it for DEB_LEN consecutive edges. A shorter pulse has no effect. After reset both filtered flags read low, so lockout and on_battery are high.
- R12: Stored bytes are unchanged across lockout and battery periods, and can be read back afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Write data from the bus |
| dq_out | output | 8 | Read data to the bus (zero when not driving) |
| dq_oe | output | 1 | Bus drive-enable |
| main_ok_raw | input | 1 | Main supply above power-fail level (asynchronous) |
| switch_ok_raw | input | 1 | Main supply above battery-switch level (asynchronous) |
| lockout | output | 1 | Access blocked by power fail |
| on_battery | output | 1 | Backup source selected |
| rec_violation | output | 1 | One-cycle pulse for an access rejected in the recovery gap |

## Verification
The bench targets the strobe orderings. It covers a write opened by chip select and closed by write strobe, and the reverse order. A design that keyed on only one strobe would store the wrong byte or none at all. The bench also covers the read-to-write transition with output enable held low: a design that dropped the bus at once, or held it too long, would miss the exact WEZ_CYC window. Accesses placed inside the recovery gap, one of them held past the gap's end, would reach the array in a design that re-checked the gap on every edge. Power-fail tests cover a write cut short by lockout, a flag glitch shorter than the filter, and both supply-select variants side by side. Each of these would show as a changed byte, a spurious lockout, or on_battery following the wrong flag.

// File: rtl/nvram_pkg.sv
package nvram_pkg;

   typedef logic [7:0] nv_byte_t;

   typedef enum logic [1:0] {
      MODE_DESEL = 2'd0,
      MODE_READ  = 2'd1,
      MODE_WRITE = 2'd2
   } nv_mode_e;

   // Strobe decode: chip select gates everything, write strobe wins over output enable
   function automatic nv_mode_e nv_decode(input logic ce_n, input logic we_n);
      if (ce_n)
         return MODE_DESEL;
      else if (!we_n)
         return MODE_WRITE;
      else
         return MODE_READ;
   endfunction

endpackage

// File: rtl/nvram_flag_filter.sv
module nvram_flag_filter #(
   parameter int unsigned DEB_LEN = 4,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);
   localparam int unsigned CW = $clog2(DEB_LEN + 1);

   logic          s1, s2;
   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1      <= RST_VAL;
         s2      <= RST_VAL;
         run_cnt <= '0;
         clean   <= RST_VAL;
      end else begin
         s1 <= raw;
         s2 <= s1;
         if (s2 == clean) begin
            run_cnt <= '0;
         end else if (run_cnt == CW'(DEB_LEN - 1)) begin
            clean   <= s2;
            run_cnt <= '0;
         end else begin
            run_cnt <= run_cnt + 1'b1;
         end
      end
   end

   AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (s2 == clean) |=> $stable(clean)); // R11

endmodule

// File: rtl/nvram_supply_sel.sv
module nvram_supply_sel #(
   parameter bit LOW_V = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic main_ok,
   input  logic switch_ok,
   output logic lockout,
   output logic on_battery
);
   logic bat_sel_d;

   generate
      if (LOW_V) begin : g_low_v
         // power-fail level lies below the switch level: change over at power fail
         assign bat_sel_d = ~main_ok;
         logic unused_switch;
         assign unused_switch = switch_ok;
      end else begin : g_std
         assign bat_sel_d = ~switch_ok;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lockout    <= 1'b1;
         on_battery <= 1'b1;
      end else begin
         lockout    <= ~main_ok;
         on_battery <= bat_sel_d;
      end
   end

endmodule

// File: rtl/nvram_byte_store.sv
module nvram_byte_store
   import nvram_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  nv_byte_t          wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output nv_byte_t          rd_data
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   nv_byte_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en)
         mem[wr_addr] <= wr_data;
      if (rd_en)
         rd_data <= mem[rd_addr];
   end

endmodule

// File: rtl/nvram_access_ctrl.sv
module nvram_access_ctrl
   import nvram_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned REC_CYC = 4,
   parameter int unsigned WEZ_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  nv_byte_t          dq_in,
   input  logic              lock,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output nv_byte_t          mem_wdata,
   output logic              mem_re,
   output logic              dq_oe,
   output logic              rec_violation
);
   localparam int unsigned RW = $clog2(REC_CYC + 1);
   localparam int unsigned ZW = $clog2(WEZ_CYC + 2);

   nv_mode_e          mode;
   logic              in_wr, rej_q, in_rec, blocked;
   logic              wr_start, wr_hold, wr_end, wr_abort;
   logic              read_ok, lag_ok, drive_d;
   logic [RW-1:0]     rec_cnt;
   logic [ZW-1:0]     lag_left;
   logic [ADDR_W-1:0] wr_addr_q;
   nv_byte_t          wr_data_q;

   assign mode    = nv_decode(ce_n, we_n);
   assign in_rec  = (rec_cnt != '0);
   assign blocked = lock | rej_q | (~ce_n & in_rec);

   // write cycle boundaries
   assign wr_start = (mode == MODE_WRITE) & ~in_wr & ~blocked;
   assign wr_hold  = (mode == MODE_WRITE) &  in_wr & ~lock;
   assign wr_end   = (mode != MODE_WRITE) &  in_wr & ~lock;
   assign wr_abort = in_wr & lock;

   // bus drive: plain read, or the short tail after write strobe falls
   assign read_ok = (mode == MODE_READ)  & ~oe_n & ~blocked;
   assign lag_ok  = (mode == MODE_WRITE) & ~oe_n & ~blocked & dq_oe & (lag_left != '0);
   assign drive_d = read_ok | lag_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_wr         <= 1'b0;
         wr_addr_q     <= '0;
         wr_data_q     <= '0;
         rec_cnt       <= '0;
         rej_q         <= 1'b0;
         rec_violation <= 1'b0;
         dq_oe         <= 1'b0;
         lag_left      <= '0;
      end else begin
         if (wr_start) begin
            in_wr     <= 1'b1;
            wr_addr_q <= addr;
            wr_data_q <= dq_in;
         end else if (wr_hold) begin
            wr_data_q <= dq_in;
         end else if (wr_end || wr_abort) begin
            in_wr <= 1'b0;
         end

         if (wr_end)
            rec_cnt <= RW'(REC_CYC);
         else if (in_rec)
            rec_cnt <= rec_cnt - 1'b1;

         rej_q         <= ~ce_n & (rej_q | (in_rec & ~lock));
         rec_violation <= ~ce_n & in_rec & ~rej_q & ~lock;

         dq_oe <= drive_d;
         if (read_ok)
            lag_left <= ZW'(WEZ_CYC);
         else if (lag_ok)
            lag_left <= lag_left - 1'b1;
         else
            lag_left <= '0;
      end
   end

   assign mem_we    = wr_end;
   assign mem_waddr = wr_addr_q;
   assign mem_wdata = wr_data_q;
   assign mem_re    = drive_d;

   AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> !dq_oe); // R1

   AST_WRITE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !we_n && !dq_oe) |=> !dq_oe); // R3

   AST_VIOL_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      rec_violation |-> $past(!ce_n)); // R6

   AST_NO_COMMIT_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      in_rec |-> !mem_we); // R6

   AST_LOCK_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> !dq_oe); // R7

   AST_LOCK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      lock |-> !mem_we); // R7

endmodule

// File: rtl/nvram_port_ctrl.sv
module nvram_port_ctrl
   import nvram_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned REC_CYC = 4,
   parameter int unsigned WEZ_CYC = 2,
   parameter int unsigned DEB_LEN = 4,
   parameter bit          LOW_V   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        dq_in,
   output logic [7:0]        dq_out,
   output logic              dq_oe,
   input  logic              main_ok_raw,
   input  logic              switch_ok_raw,
   output logic              lockout,
   output logic              on_battery,
   output logic              rec_violation
);
   generate
      if (ADDR_W < 4 || ADDR_W > 16) begin : g_bad_addr
         $error("nvram_port_ctrl: ADDR_W must lie in 4..16");
      end
      if (REC_CYC < 1 || REC_CYC > 255) begin : g_bad_rec
         $error("nvram_port_ctrl: REC_CYC must lie in 1..255");
      end
      if (WEZ_CYC > 15) begin : g_bad_wez
         $error("nvram_port_ctrl: WEZ_CYC must not exceed 15");
      end
      if (DEB_LEN < 1 || DEB_LEN > 1024) begin : g_bad_deb
         $error("nvram_port_ctrl: DEB_LEN must lie in 1..1024");
      end
   endgenerate

   logic              main_ok, switch_ok;
   logic              mem_we, mem_re;
   logic [ADDR_W-1:0] mem_waddr;
   nv_byte_t          mem_wdata, rd_data;

   nvram_flag_filter #(.DEB_LEN(DEB_LEN), .RST_VAL(1'b0)) u_main_flt (
      .clk(clk), .rst_n(rst_n), .raw(main_ok_raw), .clean(main_ok)
   );

   nvram_flag_filter #(.DEB_LEN(DEB_LEN), .RST_VAL(1'b0)) u_switch_flt (
      .clk(clk), .rst_n(rst_n), .raw(switch_ok_raw), .clean(switch_ok)
   );

   nvram_supply_sel #(.LOW_V(LOW_V)) u_supply (
      .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .switch_ok(switch_ok),
      .lockout(lockout), .on_battery(on_battery)
   );

   nvram_access_ctrl #(.ADDR_W(ADDR_W), .REC_CYC(REC_CYC), .WEZ_CYC(WEZ_CYC)) u_access (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .dq_in(dq_in), .lock(lockout),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .mem_re(mem_re), .dq_oe(dq_oe), .rec_violation(rec_violation)
   );

   nvram_byte_store #(.ADDR_W(ADDR_W)) u_store (
      .clk(clk), .wr_en(mem_we), .wr_addr(mem_waddr), .wr_data(mem_wdata),
      .rd_en(mem_re), .rd_addr(addr), .rd_data(rd_data)
   );

   assign dq_out = dq_oe ? rd_data : 8'h00;

   AST_BATT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (LOW_V ? !main_ok : !switch_ok) |=> on_battery); // R8 R9

endmodule

// File: tb/tb_nvram_port_ctrl.sv
module tb_nvram_port_ctrl;
   localparam int unsigned ADDR_W  = 12;
   localparam int unsigned REC_CYC = 4;
   localparam int unsigned WEZ_CYC = 2;
   localparam int unsigned DEB_LEN = 4;
   localparam int unsigned SETTLE  = DEB_LEN + 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [7:0]        dq_in = '0;
   logic              main_ok_raw = 1'b0, switch_ok_raw = 1'b0;
   logic [7:0]        dq_out, lv_dq_out;
   logic              dq_oe, lockout, on_battery, rec_violation;
   logic              lv_dq_oe, lv_lockout, lv_on_battery, lv_rec_violation;
   int                checks = 0;
   int                errors = 0;
   bit                done = 1'b0;

   always #2 clk = ~clk;

   nvram_port_ctrl #(.ADDR_W(ADDR_W), .REC_CYC(REC_CYC), .WEZ_CYC(WEZ_CYC),
                     .DEB_LEN(DEB_LEN), .LOW_V(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
      .main_ok_raw(main_ok_raw), .switch_ok_raw(switch_ok_raw),
      .lockout(lockout), .on_battery(on_battery), .rec_violation(rec_violation)
   );

   nvram_port_ctrl #(.ADDR_W(ADDR_W), .REC_CYC(REC_CYC), .WEZ_CYC(WEZ_CYC),
                     .DEB_LEN(DEB_LEN), .LOW_V(1'b1)) dut_lv (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .dq_in(dq_in), .dq_out(lv_dq_out), .dq_oe(lv_dq_oe),
      .main_ok_raw(main_ok_raw), .switch_ok_raw(switch_ok_raw),
      .lockout(lv_lockout), .on_battery(lv_on_battery), .rec_violation(lv_rec_violation)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic idle_bus();
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
   endtask

   // write: chip select and strobe low for two edges, released, optional gap wait
   task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, input bit wait_gap);
      addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      cyc(2);
      idle_bus();
      if (wait_gap) cyc(REC_CYC + 1);
   endtask

   task automatic rd(input string req, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
      addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      cyc(1);
      chk(req, "read drive", dq_oe, 1'b1);
      chk(req, "read data", dq_out, exp);
      idle_bus();
      cyc(1);
   endtask

   task automatic t_reset();
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk("R11", "lockout after reset", lockout, 1'b1);
      chk("R11", "on_battery after reset", on_battery, 1'b1);
      chk("R1", "drive after reset", dq_oe, 1'b0);
      chk("R6", "violation after reset", rec_violation, 1'b0);
      main_ok_raw = 1'b1; switch_ok_raw = 1'b1;
      cyc(SETTLE);
      chk("R11", "lockout after supply good", lockout, 1'b0);
      chk("R8", "on_battery after supply good", on_battery, 1'b0);
   endtask

   task automatic t_basic();
      wr(12'h000, 8'h5A, 1'b1);
      wr(12'hFFF, 8'hA5, 1'b1);
      wr(12'h123, 8'h3C, 1'b1);
      rd("R2", 12'h000, 8'h5A);
      rd("R2", 12'hFFF, 8'hA5);
      rd("R5", 12'h123, 8'h3C);
      addr = 12'h000; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
      cyc(1);
      chk("R2", "no drive with output enable high", dq_oe, 1'b0);
      idle_bus();
      cyc(1);
   endtask

   task automatic t_deselect();
      addr = 12'h000; dq_in = 8'hEE; ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b0;
      cyc(1);
      chk("R1", "deselect drive", dq_oe, 1'b0);
      cyc(2);
      chk("R1", "deselect drive held", dq_oe, 1'b0);
      idle_bus();
      cyc(1);
      rd("R1", 12'h000, 8'h5A);
   endtask

   task automatic t_write_lag();
      addr = 12'h123; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      cyc(1);
      chk("R4", "drive before strobe", dq_oe, 1'b1);
      we_n = 1'b0; dq_in = 8'h77;
      for (int k = 1; k <= WEZ_CYC; k++) begin
         cyc(1);
         chk("R4", "drive during lag", dq_oe, 1'b1);
         chk("R4", "lag data is old byte", dq_out, 8'h3C);
      end
      cyc(1);
      chk("R4", "drive released after lag", dq_oe, 1'b0);
      cyc(1);
      chk("R3", "drive stays released in write", dq_oe, 1'b0);
      idle_bus();
      cyc(REC_CYC + 1);
      rd("R3", 12'h123, 8'h77);
   endtask

   task automatic t_strobe_order();
      // strobe first, chip select last; closed by chip select with strobe still low
      addr = 12'h0F0; dq_in = 8'h11; ce_n = 1'b1; we_n = 1'b0;
      cyc(1);
      ce_n = 1'b0; dq_in = 8'h22;
      cyc(1);
      dq_in = 8'h33;
      cyc(1);
      addr = 12'h0F1;
      ce_n = 1'b1; dq_in = 8'h44;
      cyc(1);
      we_n = 1'b1;
      cyc(REC_CYC);
      rd("R5", 12'h0F0, 8'h33);
   endtask

   task automatic t_recovery();
      wr(12'h200, 8'h81, 1'b0);
      cyc(1);
      addr = 12'h200; dq_in = 8'hFF; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      cyc(1);
      chk("R6", "violation on early write", rec_violation, 1'b1);
      cyc(1);
      chk("R6", "violation is a pulse", rec_violation, 1'b0);
      cyc(REC_CYC + 2);
      idle_bus();
      cyc(1);
      rd("R6", 12'h200, 8'h81);
      wr(12'h201, 8'h82, 1'b0);
      cyc(1);
      addr = 12'h200; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      cyc(1);
      chk("R6", "violation on early read", rec_violation, 1'b1);
      chk("R6", "early read not driven", dq_oe, 1'b0);
      cyc(REC_CYC + 2);
      chk("R6", "held early read stays rejected", dq_oe, 1'b0);
      idle_bus();
      cyc(1);
      rd("R6", 12'h201, 8'h82);
   endtask

   task automatic t_lockout();
      main_ok_raw = 1'b0;
      cyc(SETTLE);
      chk("R7", "lockout on power fail", lockout, 1'b1);
      chk("R8", "standard keeps main supply", on_battery, 1'b0);
      chk("R9", "low-voltage variant on battery", lv_on_battery, 1'b1);
      addr = 12'h000; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      cyc(1);
      chk("R7", "no read while locked", dq_oe, 1'b0);
      idle_bus();
      wr(12'h000, 8'hC3, 1'b0);
      main_ok_raw = 1'b1;
      cyc(SETTLE);
      chk("R7", "lockout cleared", lockout, 1'b0);
      chk("R9", "low-voltage variant back on main", lv_on_battery, 1'b0);
      rd("R7", 12'h000, 8'h5A);
   endtask

   task automatic t_battery();
      main_ok_raw = 1'b0; switch_ok_raw = 1'b0;
      cyc(SETTLE);
      chk("R8", "battery selected", on_battery, 1'b1);
      main_ok_raw = 1'b1;
      cyc(SETTLE);
      chk("R8", "battery held while switch flag low", on_battery, 1'b1);
      chk("R9", "low-voltage variant ignores switch flag", lv_on_battery, 1'b0);
      switch_ok_raw = 1'b1;
      cyc(SETTLE);
      chk("R8", "main supply selected again", on_battery, 1'b0);
      rd("R12", 12'hFFF, 8'hA5);
      rd("R12", 12'h0F0, 8'h33);
   endtask

   task automatic t_abort();
      addr = 12'h300; dq_in = 8'h10;
      wr(12'h300, 8'h10, 1'b1);
      addr = 12'h300; dq_in = 8'h99; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      cyc(2);
      main_ok_raw = 1'b0;
      cyc(SETTLE);
      chk("R10", "locked during write", lockout, 1'b1);
      idle_bus();
      cyc(1);
      main_ok_raw = 1'b1;
      cyc(SETTLE);
      rd("R10", 12'h300, 8'h10);
   endtask

   task automatic t_glitch();
      main_ok_raw = 1'b0;
      cyc(DEB_LEN - 2);
      main_ok_raw = 1'b1;
      for (int k = 0; k < SETTLE; k++) begin
         cyc(1);
         chk("R11", "short dip ignored", lockout, 1'b0);
      end
      switch_ok_raw = 1'b0;
      cyc(DEB_LEN - 2);
      switch_ok_raw = 1'b1;
      cyc(SETTLE);
      chk("R11", "short switch dip ignored", on_battery, 1'b0);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_deselect();
      t_write_lag();
      t_strobe_order();
      t_recovery();
      t_lockout();
      t_battery();
      t_abort();
      t_glitch();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule